// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block runs whole I2C transactions on top of a byte-level bus engine. Software, or a neighbouring controller, hands it one command: a probe, a read or a write. The command carries a 7-bit device address, a memory address of zero to `MADDR_BYTES` bytes and a data byte count. The sequencer then issues each bus step to the engine in turn: start, address byte, memory address bytes, repeated start, data bytes and stop. After each step it compares the status code that the engine reports with the one exact code that the step should produce.

Write data arrives on a valid/ready byte stream, and read data leaves on a second one. Each wait for the engine is bounded by a poll counter. The transaction always ends with a stop. The sequencer then returns a 32-bit result word with a one-cycle `done` pulse. The word is zero on success. Otherwise it holds an error class, the control value involved, the status that was seen and the status that was expected.

Top module: `i2c_txn_sequencer`

## Requirements
- R1: A command is taken only while `cmd_ready` is high, which is only in the idle state. `cmd_valid` is ignored at all other times. `cmd_op` is coded 1 = read and 2 = write; any other value (0 or 3) is a probe. `cmd_alen` values above `MADDR_BYTES` are treated as `MADDR_BYTES`. Each transaction raises `done` for exactly one cycle, together with a valid `result`.
- R2: A read issues, in order: start (control 0x60, expected 0x08); device address with bit 0 = 0 (control 0x40, expected 0x18); the memory address bytes, most significant first (control 0x40, expected 0x28 each); a repeated start with no stop before it (control 0x60, expected 0x10); device address with bit 0 = 1 (control 0x40, expected 0x40); the data receives; stop.
- R3: After each engine command the engine is polled once every `POLL_GAP` cycles, for at most `POLL_LIMIT` polls. If the engine flag is still low at the last poll, the error class is 2 (timeout). The control field then holds the issued control value without bit 3, and the status field holds the engine status at that poll.
- R4: A flagged step whose status differs from its expected code gives error class 1 (mismatch). The control field is the issued control value with bit 3 (0x08) set. Result layout: [31:24] class, [23:16] control, [15:8] status seen, [7:0] expected status.
- R5: Control bits are: enable 0x40, start 0x20, stop 0x10, acknowledge 0x04. Every received data byte except the last is acknowledged (control 0x44, expected 0x50). The last is not acknowledged (control 0x40, expected 0x58).
- R6: A probe issues start, then the device address with bit 0 = 1 (expected 0x40), then one receive without acknowledge (expected 0x58), then stop. The received byte is not sent to the read stream.
- R7: A write issues start, then the device address with bit 0 = 0, then the memory address bytes (most significant first), then one send per byte taken from the write stream (control 0x40, expected 0x28), then stop.
- R8: A stop (control 0x50) is issued at the end of every transaction, including after an error. The first error is the one reported. A stop timeout is reported only when no earlier error occurred; its result is class 2, control 0x50, the last status seen and expected 0xF8.
- R9: The stop wait is complete when the engine status reads 0xF8. It does not wait for the engine flag.
- R10: A transaction in which every step matches returns `result` = 0.
- R11: Read bytes leave on `rd_data` in bus order and are held while `rd_valid` is high and `rd_ready` is low. Exactly one write-stream byte is taken per data send.
- R12: A memory address length of 0 skips the address bytes. A data length of 0 gives a read or write with no data steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, command accepted when valid |
| cmd_op | input | 2 | 1 read, 2 write, otherwise probe |
| cmd_chip | input | 7 | Device address |
| cmd_maddr | input | 8*MADDR_BYTES | Memory address, byte 0 least significant |
| cmd_alen | input | $clog2(MADDR_BYTES+1) | Number of memory address bytes |
| cmd_len | input | LEN_W | Number of data bytes |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle when valid |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken this cycle when valid |
| rd_data | output | 8 | Read byte |
| eng_cmd | output | 1 | One-cycle command strobe to the byte engine |
| eng_ctrl | output | 8 | Control value for the command |
| eng_tx | output | 8 | Byte to send (address or data) |
| eng_flag | input | 1 | Engine step-complete flag, cleared by a new command |
| eng_status | input | 8 | Engine status code |
| eng_rx | input | 8 | Byte received by the engine |
| done | output | 1 | One-cycle result strobe |
| result | output | 32 | Zero or packed error word |

## Verification
A wrong step or address index shows up on the next `eng_cmd` strobe, as a control value or sent byte out of order, one engine latency after the previous step completes. A wrong remaining-byte counter shows up as one data strobe too many or too few, and as a wrong acknowledge bit on the last receive. A fault in error capture or stop handling becomes visible only at the `done` pulse, as a wrong field in `result`. For that reason each error class is provoked at a known step, and the expected word is built field by field.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [1:0] {
        OP_PROBE = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    localparam logic [7:0] CTL_ACK   = 8'h04;
    localparam logic [7:0] CTL_FLAG  = 8'h08;
    localparam logic [7:0] CTL_STOP  = 8'h10;
    localparam logic [7:0] CTL_START = 8'h20;
    localparam logic [7:0] CTL_EN    = 8'h40;

    localparam logic [7:0] SC_START  = 8'h08;
    localparam logic [7:0] SC_RSTART = 8'h10;
    localparam logic [7:0] SC_AW_ACK = 8'h18;
    localparam logic [7:0] SC_DW_ACK = 8'h28;
    localparam logic [7:0] SC_AR_ACK = 8'h40;
    localparam logic [7:0] SC_DR_ACK = 8'h50;
    localparam logic [7:0] SC_DR_NAK = 8'h58;
    localparam logic [7:0] SC_IDLE   = 8'hF8;

    localparam logic [7:0] ERR_MISMATCH = 8'h01;
    localparam logic [7:0] ERR_TIMEOUT  = 8'h02;

    typedef enum logic [2:0] {
        STEP_START,
        STEP_ADDR_W,
        STEP_MADDR,
        STEP_RSTART,
        STEP_ADDR_R,
        STEP_RDATA,
        STEP_WDATA,
        STEP_DUMMY
    } step_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_RDOUT,
        SQ_WRIN,
        SQ_STOP_ISSUE,
        SQ_STOP_WAIT
    } seq_state_e;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] tx;
        logic [7:0] exp_code;
    } drive_t;

    typedef struct packed {
        logic [7:0] err_class;
        logic [7:0] ctrl;
        logic [7:0] status;
        logic [7:0] exp_code;
    } result_t;

    function automatic result_t make_result(input logic [7:0] cls,
                                            input logic [7:0] ctrl,
                                            input logic [7:0] status,
                                            input logic [7:0] exp_code);
        result_t r;
        r.err_class = cls;
        r.ctrl      = ctrl;
        r.status    = status;
        r.exp_code  = exp_code;
        return r;
    endfunction

endpackage

// File: rtl/i2cseq_poll.sv
module i2cseq_poll
    import i2cseq_pkg::*;
#(
    parameter int LIMIT = 1000,
    parameter int GAP   = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       launch,
    input  logic       idle_mode,
    input  logic       flag,
    input  logic [7:0] status,
    output logic       fin,
    output logic       fin_timeout,
    output logic [7:0] fin_status
);
    localparam int GW     = (GAP > 1) ? $clog2(GAP) : 1;
    localparam int LW     = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam int SPAN   = LIMIT * GAP;
    localparam int LIFE_W = $clog2(SPAN + 1);

    logic          active_q;
    logic [GW-1:0] gap_q;
    logic [LW-1:0] poll_q;
    logic          tick, cond, last;

    assign tick        = active_q && (gap_q == GW'(GAP - 1));
    assign cond        = idle_mode ? (status == SC_IDLE) : flag;
    assign last        = (poll_q == LW'(LIMIT - 1));
    assign fin         = tick && (cond || last);
    assign fin_timeout = tick && !cond && last;
    assign fin_status  = status;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            gap_q    <= '0;
            poll_q   <= '0;
        end else if (launch) begin
            active_q <= 1'b1;
            gap_q    <= '0;
            poll_q   <= '0;
        end else if (active_q) begin
            if (tick) begin
                gap_q <= '0;
                if (cond || last) active_q <= 1'b0;
                else              poll_q   <= poll_q + LW'(1);
            end else begin
                gap_q <= gap_q + GW'(1);
            end
        end
    end

    // Independent lifetime counter: a wait never outlives LIMIT*GAP cycles.
    logic [LIFE_W-1:0] life_q;
    always_ff @(posedge clk) begin
        if (rst || launch) life_q <= '0;
        else if (active_q) life_q <= life_q + LIFE_W'(1);
    end

    assert_poll_window_R3: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (int'(life_q) < SPAN));

endmodule

// File: rtl/i2cseq_mbyte.sv
module i2cseq_mbyte #(
    parameter int NB = 4,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [8*NB-1:0] maddr,
    input  logic [IW-1:0]   idx,
    output logic [7:0]      mbyte
);
    logic [7:0] lanes [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lanes[g] = maddr[8*g +: 8];
    end

    always_comb begin
        mbyte = 8'h00;
        for (int k = 0; k < NB; k++)
            if (int'(idx) == k) mbyte = lanes[k];
    end
endmodule

// File: rtl/i2cseq_step_decode.sv
module i2cseq_step_decode
    import i2cseq_pkg::*;
(
    input  step_e      step,
    input  logic       stopping,
    input  logic [6:0] chip,
    input  logic [7:0] mbyte,
    input  logic [7:0] wbyte,
    input  logic       last_rx,
    output drive_t     drv
);
    always_comb begin
        drv = '{ctrl: CTL_EN, tx: 8'h00, exp_code: SC_IDLE};
        if (stopping) begin
            drv.ctrl     = CTL_EN | CTL_STOP;
            drv.exp_code = SC_IDLE;
        end else begin
            case (step)
                STEP_START:  begin drv.ctrl = CTL_EN | CTL_START; drv.exp_code = SC_START; end
                STEP_ADDR_W: begin drv.tx = {chip, 1'b0}; drv.exp_code = SC_AW_ACK; end
                STEP_MADDR:  begin drv.tx = mbyte; drv.exp_code = SC_DW_ACK; end
                STEP_RSTART: begin drv.ctrl = CTL_EN | CTL_START; drv.exp_code = SC_RSTART; end
                STEP_ADDR_R: begin drv.tx = {chip, 1'b1}; drv.exp_code = SC_AR_ACK; end
                STEP_RDATA: begin
                    drv.ctrl     = last_rx ? CTL_EN : (CTL_EN | CTL_ACK);
                    drv.exp_code = last_rx ? SC_DR_NAK : SC_DR_ACK;
                end
                STEP_WDATA:  begin drv.tx = wbyte; drv.exp_code = SC_DW_ACK; end
                default:     begin drv.exp_code = SC_DR_NAK; end
            endcase
        end
    end
endmodule

// File: rtl/i2c_txn_sequencer.sv
module i2c_txn_sequencer
    import i2cseq_pkg::*;
#(
    parameter int MADDR_BYTES = 4,
    parameter int LEN_W       = 8,
    parameter int POLL_LIMIT  = 1000,
    parameter int POLL_GAP    = 1000,
    localparam int AW = $clog2(MADDR_BYTES + 1),
    localparam int IW = (MADDR_BYTES > 1) ? $clog2(MADDR_BYTES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [1:0]               cmd_op,
    input  logic [6:0]               cmd_chip,
    input  logic [8*MADDR_BYTES-1:0] cmd_maddr,
    input  logic [AW-1:0]            cmd_alen,
    input  logic [LEN_W-1:0]         cmd_len,
    input  logic                     wr_valid,
    output logic                     wr_ready,
    input  logic [7:0]               wr_data,
    output logic                     rd_valid,
    input  logic                     rd_ready,
    output logic [7:0]               rd_data,
    output logic                     eng_cmd,
    output logic [7:0]               eng_ctrl,
    output logic [7:0]               eng_tx,
    input  logic                     eng_flag,
    input  logic [7:0]               eng_status,
    input  logic [7:0]               eng_rx,
    output logic                     done,
    output logic [31:0]              result
);
    seq_state_e               state_q, post_state;
    step_e                    step_q, post_step;
    op_e                      op_q;
    logic [6:0]               chip_q;
    logic [8*MADDR_BYTES-1:0] maddr_q;
    logic [AW-1:0]            alen_q, alen_in;
    logic [IW-1:0]            idx_q;
    logic [LEN_W-1:0]         remain_q;
    logic [7:0]               wbyte_q, rbyte_q, mbyte;
    result_t                  err_q, result_q;
    logic                     err_seen_q, done_q;
    logic                     stopping, launch;
    logic                     fin, fin_timeout;
    logic [7:0]               fin_status;
    drive_t                   drv;

    assign stopping = (state_q == SQ_STOP_ISSUE) || (state_q == SQ_STOP_WAIT);
    assign launch   = (state_q == SQ_ISSUE) || (state_q == SQ_STOP_ISSUE);
    assign alen_in  = (int'(cmd_alen) > MADDR_BYTES) ? AW'(MADDR_BYTES) : cmd_alen;

    i2cseq_mbyte #(.NB(MADDR_BYTES)) i_mbyte (
        .maddr (maddr_q),
        .idx   (idx_q),
        .mbyte (mbyte)
    );

    i2cseq_step_decode i_decode (
        .step     (step_q),
        .stopping (stopping),
        .chip     (chip_q),
        .mbyte    (mbyte),
        .wbyte    (wbyte_q),
        .last_rx  (remain_q == LEN_W'(1)),
        .drv      (drv)
    );

    i2cseq_poll #(.LIMIT(POLL_LIMIT), .GAP(POLL_GAP)) i_poll (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .idle_mode   (stopping),
        .flag        (eng_flag),
        .status      (eng_status),
        .fin         (fin),
        .fin_timeout (fin_timeout),
        .fin_status  (fin_status)
    );

    // Where to go once the memory address bytes are finished.
    always_comb begin
        post_state = SQ_STOP_ISSUE;
        post_step  = step_q;
        if (op_q == OP_READ) begin
            post_state = SQ_ISSUE;
            post_step  = STEP_RSTART;
        end else if (remain_q != '0) begin
            post_state = SQ_WRIN;
            post_step  = STEP_WDATA;
        end
    end

    always_ff @(posedge clk) begin
        done_q <= 1'b0;
        if (rst) begin
            state_q    <= SQ_IDLE;
            step_q     <= STEP_START;
            op_q       <= OP_PROBE;
            chip_q     <= '0;
            maddr_q    <= '0;
            alen_q     <= '0;
            idx_q      <= '0;
            remain_q   <= '0;
            wbyte_q    <= '0;
            rbyte_q    <= '0;
            err_q      <= '0;
            err_seen_q <= 1'b0;
            result_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (cmd_valid) begin
                    op_q       <= (cmd_op == 2'd1) ? OP_READ :
                                  (cmd_op == 2'd2) ? OP_WRITE : OP_PROBE;
                    chip_q     <= cmd_chip;
                    maddr_q    <= cmd_maddr;
                    alen_q     <= alen_in;
                    remain_q   <= cmd_len;
                    err_seen_q <= 1'b0;
                    step_q     <= STEP_START;
                    state_q    <= SQ_ISSUE;
                end
                SQ_ISSUE: state_q <= SQ_WAIT;
                SQ_WAIT: if (fin) begin
                    if (fin_timeout) begin
                        err_q      <= make_result(ERR_TIMEOUT, drv.ctrl, fin_status, drv.exp_code);
                        err_seen_q <= 1'b1;
                        state_q    <= SQ_STOP_ISSUE;
                    end else if (fin_status != drv.exp_code) begin
                        err_q      <= make_result(ERR_MISMATCH, drv.ctrl | CTL_FLAG,
                                                  fin_status, drv.exp_code);
                        err_seen_q <= 1'b1;
                        state_q    <= SQ_STOP_ISSUE;
                    end else begin
                        case (step_q)
                            STEP_START: begin
                                step_q  <= (op_q == OP_PROBE) ? STEP_ADDR_R : STEP_ADDR_W;
                                state_q <= SQ_ISSUE;
                            end
                            STEP_ADDR_W: if (alen_q != '0) begin
                                step_q  <= STEP_MADDR;
                                idx_q   <= IW'(alen_q - AW'(1));
                                state_q <= SQ_ISSUE;
                            end else begin
                                step_q  <= post_step;
                                state_q <= post_state;
                            end
                            STEP_MADDR: if (idx_q != '0) begin
                                idx_q   <= idx_q - IW'(1);
                                state_q <= SQ_ISSUE;
                            end else begin
                                step_q  <= post_step;
                                state_q <= post_state;
                            end
                            STEP_RSTART: begin
                                step_q  <= STEP_ADDR_R;
                                state_q <= SQ_ISSUE;
                            end
                            STEP_ADDR_R: if (op_q == OP_PROBE) begin
                                step_q  <= STEP_DUMMY;
                                state_q <= SQ_ISSUE;
                            end else if (remain_q != '0) begin
                                step_q  <= STEP_RDATA;
                                state_q <= SQ_ISSUE;
                            end else begin
                                state_q <= SQ_STOP_ISSUE;
                            end
                            STEP_RDATA: begin
                                rbyte_q <= eng_rx;
                                state_q <= SQ_RDOUT;
                            end
                            STEP_WDATA: begin
                                remain_q <= remain_q - LEN_W'(1);
                                state_q  <= (remain_q == LEN_W'(1)) ? SQ_STOP_ISSUE : SQ_WRIN;
                            end
                            default: state_q <= SQ_STOP_ISSUE;
                        endcase
                    end
                end
                SQ_RDOUT: if (rd_ready) begin
                    remain_q <= remain_q - LEN_W'(1);
                    state_q  <= (remain_q == LEN_W'(1)) ? SQ_STOP_ISSUE : SQ_ISSUE;
                end
                SQ_WRIN: if (wr_valid) begin
                    wbyte_q <= wr_data;
                    state_q <= SQ_ISSUE;
                end
                SQ_STOP_ISSUE: state_q <= SQ_STOP_WAIT;
                SQ_STOP_WAIT: if (fin) begin
                    if (err_seen_q)       result_q <= err_q;
                    else if (fin_timeout) result_q <= make_result(ERR_TIMEOUT, CTL_EN | CTL_STOP,
                                                                  fin_status, SC_IDLE);
                    else                  result_q <= '0;
                    done_q  <= 1'b1;
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state_q == SQ_IDLE);
    assign wr_ready  = (state_q == SQ_WRIN);
    assign rd_valid  = (state_q == SQ_RDOUT);
    assign rd_data   = rbyte_q;
    assign eng_cmd   = launch;
    assign eng_ctrl  = drv.ctrl;
    assign eng_tx    = drv.tx;
    assign done      = done_q;
    assign result    = result_q;

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_stop_before_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state_q == SQ_STOP_WAIT));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_wr_to_engine_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (eng_cmd && eng_tx == $past(wr_data)));

    assert_cmd_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        eng_cmd |=> !eng_cmd);

endmodule

// File: tb/test_i2c_txn_sequencer.sv
module test_i2c_txn_sequencer;
    localparam int MB   = 4;
    localparam int LW   = 8;
    localparam int LIM  = 4;
    localparam int GAP  = 2;
    localparam int AWB  = $clog2(MB + 1);
    localparam int NEVER = 255;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'd0;
    logic [6:0]    cmd_chip = '0;
    logic [8*MB-1:0] cmd_maddr = '0;
    logic [AWB-1:0] cmd_alen = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          wr_valid, wr_ready, rd_valid, rd_ready;
    logic [7:0]    wr_data, rd_data;
    logic          eng_cmd, done;
    logic [7:0]    eng_ctrl, eng_tx;
    logic          eng_flag = 1'b0;
    logic [7:0]    eng_status = 8'hF8;
    logic [7:0]    eng_rx = 8'h00;
    logic [31:0]   result;

    i2c_txn_sequencer #(.MADDR_BYTES(MB), .LEN_W(LW), .POLL_LIMIT(LIM), .POLL_GAP(GAP))
    i_i2c_txn_sequencer (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_chip(cmd_chip), .cmd_maddr(cmd_maddr),
        .cmd_alen(cmd_alen), .cmd_len(cmd_len), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_data(rd_data), .eng_cmd(eng_cmd),
        .eng_ctrl(eng_ctrl), .eng_tx(eng_tx), .eng_flag(eng_flag),
        .eng_status(eng_status), .eng_rx(eng_rx), .done(done), .result(result)
    );

    int checks = 0;
    int errors = 0;

    // Script and expectation tables
    logic [7:0] exp_ctrl [32];
    logic [7:0] exp_tx   [32];
    logic [7:0] scr_code [32];
    int         scr_lat  [32];
    int         exp_n;
    logic [7:0] wdata    [16];

    // Engine model and monitors
    logic       eng_clr = 1'b0;
    logic [7:0] log_ctrl [32];
    logic [7:0] log_tx   [32];
    int         eng_n = 0;
    int         pend = 0;
    int         cur_idx = 0;
    logic [7:0] cur_code = 8'h00;
    logic       cur_stop = 1'b0;
    logic [7:0] rcap [16];
    int         rcnt = 0;
    int         wr_idx = 0;
    int         done_cnt = 0;
    logic [31:0] res_cap = '0;
    logic [7:0] cyc = '0;

    function automatic logic [7:0] rxval(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 8'd1;
        if (rst || eng_clr) begin
            eng_n <= 0; pend <= 0; eng_flag <= 1'b0; eng_status <= 8'hF8;
            rcnt <= 0; wr_idx <= 0;
        end else begin
            if (eng_cmd) begin
                log_ctrl[eng_n & 31] <= eng_ctrl;
                log_tx[eng_n & 31]   <= eng_tx;
                eng_flag <= 1'b0;
                pend     <= scr_lat[eng_n & 31];
                cur_code <= scr_code[eng_n & 31];
                cur_stop <= eng_ctrl[4];
                cur_idx  <= eng_n;
                eng_n    <= eng_n + 1;
            end else if (pend != 0 && pend != NEVER) begin
                if (pend == 1) begin
                    eng_status <= cur_code;
                    eng_rx     <= rxval(cur_idx);
                    if (!cur_stop) eng_flag <= 1'b1;
                end
                pend <= pend - 1;
            end
            if (rd_valid && rd_ready) begin
                rcap[rcnt & 15] <= rd_data;
                rcnt <= rcnt + 1;
            end
            if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
        end
        if (!rst && done) begin
            done_cnt <= done_cnt + 1;
            res_cap  <= result;
        end
    end

    assign rd_ready = cyc[0];
    assign wr_valid = 1'b1;
    assign wr_data  = wdata[wr_idx & 15];

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic add(input logic [7:0] c, input logic [7:0] t, input logic [7:0] code);
        exp_ctrl[exp_n] = c; exp_tx[exp_n] = t; scr_code[exp_n] = code; scr_lat[exp_n] = 1;
        exp_n++;
    endtask

    task automatic build(input int op, input logic [6:0] chip, input int alen,
                         input logic [31:0] maddr, input int len);
        exp_n = 0;
        for (int i = 0; i < 32; i++) scr_lat[i] = 1;
        add(8'h60, 8'h00, 8'h08);
        if (op != 0) add(8'h40, {chip, 1'b0}, 8'h18);
        for (int k = alen - 1; k >= 0; k--) add(8'h40, 8'(maddr >> (8 * k)), 8'h28);
        if (op == 1) add(8'h60, 8'h00, 8'h10);
        if (op != 2) add(8'h40, {chip, 1'b1}, 8'h40);
        if (op == 0) add(8'h40, 8'h00, 8'h58);
        if (op == 1)
            for (int j = 0; j < len; j++)
                add((j < len - 1) ? 8'h44 : 8'h40, 8'h00, (j < len - 1) ? 8'h50 : 8'h58);
        if (op == 2)
            for (int j = 0; j < len; j++) add(8'h40, wdata[j], 8'h28);
        add(8'h50, 8'h00, 8'hF8);
    endtask

    task automatic run(input int op, input logic [6:0] chip, input int alen,
                       input logic [31:0] maddr, input int len, input bit poke);
        int start_done;
        int waited;
        @(negedge clk);
        eng_clr = 1'b1;
        @(negedge clk);
        eng_clr   = 1'b0;
        start_done = done_cnt;
        cmd_op    = 2'(op);
        cmd_chip  = chip;
        cmd_maddr = maddr;
        cmd_alen  = AWB'(alen);
        cmd_len   = LW'(len);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = poke;
        if (poke) begin
            cmd_op = 2'd2; cmd_chip = 7'h7F; cmd_len = 8'd9;
            chk(cmd_ready == 1'b0, "R1 cmd_ready low while busy", 32'(cmd_ready), 32'd0);
            repeat (2) @(negedge clk);
            cmd_valid = 1'b0;
        end
        waited = 0;
        while (done_cnt == start_done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        chk(waited < 3000, "watchdog: transaction finished", 32'(waited), 32'd3000);
        repeat (3) @(negedge clk);
        chk(done_cnt == start_done + 1, "R1 single done pulse", 32'(done_cnt - start_done), 32'd1);
    endtask

    task automatic check_log(input string tag);
        chk(eng_n == exp_n, {tag, " command count"}, 32'(eng_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < eng_n; i++) begin
            chk(log_ctrl[i] == exp_ctrl[i], {tag, " control"}, 32'(log_ctrl[i]), 32'(exp_ctrl[i]));
            chk(log_tx[i] == exp_tx[i], {tag, " sent byte"}, 32'(log_tx[i]), 32'(exp_tx[i]));
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) wdata[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(cmd_ready == 1'b1, "R1 reset cmd_ready", 32'(cmd_ready), 32'd1);
        chk(done == 1'b0 && eng_cmd == 1'b0, "R1 reset done/eng_cmd", {30'd0, done, eng_cmd}, 32'd0);
        chk(rd_valid == 1'b0 && wr_ready == 1'b0, "R11 reset streams", {30'd0, rd_valid, wr_ready}, 32'd0);

        // R2 R5 R7 R10 R11 R12: sweep of reads and writes
        for (int op = 1; op <= 2; op++)
            for (int alen = 0; alen <= MB; alen++)
                for (int len = 0; len <= 3; len++) begin
                    logic [31:0] ma;
                    logic [6:0]  ch;
                    ma = 32'hA1B2C3D4 ^ 32'(len * 32'h01010101);
                    ch = 7'(7'h50 + alen + 8 * len);
                    for (int j = 0; j < 16; j++) wdata[j] = 8'((j * 53 + 11 + alen + len) & 255);
                    build(op, ch, alen, ma, len);
                    run(op, ch, alen, ma, len, alen == 2);
                    chk(res_cap == 32'd0, "R10 success result", res_cap, 32'd0);
                    check_log((op == 1) ? "R2 R5 R12 read order" : "R7 R12 write order");
                    if (op == 1) begin
                        chk(rcnt == len, "R11 read byte count", 32'(rcnt), 32'(len));
                        for (int j = 0; j < len && j < rcnt; j++)
                            chk(rcap[j] == rxval(alen + 4 + j), "R11 read byte value",
                                32'(rcap[j]), 32'(rxval(alen + 4 + j)));
                    end else begin
                        chk(wr_idx == len, "R11 write bytes taken", 32'(wr_idx), 32'(len));
                    end
                end

        // R6: probe success
        build(0, 7'h2A, 0, 32'd0, 0);
        run(0, 7'h2A, 0, 32'd0, 0, 1'b0);
        chk(res_cap == 32'd0, "R6 probe result", res_cap, 32'd0);
        check_log("R6 probe order");
        chk(rcnt == 0, "R6 probe byte not streamed", 32'(rcnt), 32'd0);

        // R4 R8: probe address not acknowledged
        build(0, 7'h2A, 0, 32'd0, 0);
        scr_code[1] = 8'h48;
        run(0, 7'h2A, 0, 32'd0, 0, 1'b0);
        chk(res_cap == 32'h01484840, "R4 mismatch word", res_cap, 32'h01484840);
        chk(eng_n == 3 && log_ctrl[2] == 8'h50, "R8 stop after error", 32'(eng_n), 32'd3);

        // R4 R5: mismatch on an acknowledged receive
        build(1, 7'h33, 1, 32'h000000BE, 2);
        scr_code[5] = 8'h58;
        run(1, 7'h33, 1, 32'h000000BE, 2, 1'b0);
        chk(res_cap == 32'h014C5850, "R5 R4 acked receive mismatch", res_cap, 32'h014C5850);
        chk(rcnt == 0, "R4 failed byte not streamed", 32'(rcnt), 32'd0);
        chk(eng_n == 7 && log_ctrl[6] == 8'h50, "R8 stop after receive error", 32'(eng_n), 32'd7);

        // R3: timeout on a memory address byte
        build(2, 7'h11, 2, 32'h00001234, 1);
        scr_lat[2] = NEVER;
        run(2, 7'h11, 2, 32'h00001234, 1, 1'b0);
        chk(res_cap == 32'h02401828, "R3 timeout word", res_cap, 32'h02401828);
        chk(eng_n == 4 && log_ctrl[3] == 8'h50, "R3 R8 stop after timeout", 32'(eng_n), 32'd4);

        // R3: flag at the last poll is still accepted
        build(2, 7'h12, 0, 32'd0, 0);
        scr_lat[1] = 7;
        run(2, 7'h12, 0, 32'd0, 0, 1'b0);
        chk(res_cap == 32'd0, "R3 flag at last poll", res_cap, 32'd0);

        // R3: flag one cycle after the last poll is a timeout
        build(2, 7'h12, 0, 32'd0, 0);
        scr_lat[1] = 8;
        run(2, 7'h12, 0, 32'd0, 0, 1'b0);
        chk(res_cap == 32'h02400818, "R3 flag after last poll", res_cap, 32'h02400818);

        // R8 R9: stop never reaches idle, no earlier error
        build(2, 7'h21, 1, 32'h00000077, 1);
        scr_lat[4] = NEVER;
        run(2, 7'h21, 1, 32'h00000077, 1, 1'b0);
        chk(res_cap == 32'h025028F8, "R9 R8 stop timeout word", res_cap, 32'h025028F8);

        // R9: stop reports a non-idle code while the flag stays low
        build(2, 7'h22, 0, 32'd0, 0);
        scr_code[2] = 8'h50;
        run(2, 7'h22, 0, 32'd0, 0, 1'b0);
        chk(res_cap == 32'h025050F8, "R9 stop waits for idle code", res_cap, 32'h025050F8);

        // R8: first error kept when the stop also times out
        build(0, 7'h2A, 0, 32'd0, 0);
        scr_code[1] = 8'h48;
        scr_lat[2]  = NEVER;
        run(0, 7'h2A, 0, 32'd0, 0, 1'b0);
        chk(res_cap == 32'h01484840, "R8 first error kept", res_cap, 32'h01484840);

        // R1: out-of-range op code acts as probe, oversize address length clamps
        build(0, 7'h05, 0, 32'd0, 0);
        run(3, 7'h05, 0, 32'd0, 0, 1'b0);
        check_log("R1 op code 3 as probe");
        build(2, 7'h06, MB, 32'h0A0B0C0D, 0);
        run(2, 7'h06, 7, 32'h0A0B0C0D, 0, 1'b0);
        check_log("R1 address length clamp");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule